// File: doc/BRIEF.md
# SMM Soft-Reset and Address-Wrap Gate

This block sits between the chipset's reset and address-wrap sources and a processor that has a system-management mode. It sees the management interrupt request, the processor's management-active indication and a bus-cycle-start strobe. From these it decides when the processor may safely receive a soft reset or an asserted address-wrap (A20 mask) request.

While the processor is in management mode, the address-wrap output is held inactive. Soft resets are withheld from the first cycle after a management request is sampled. They stay withheld until a guard window after the active indication drops has run out, or until a bus cycle starts, whichever comes first. A soft reset that arrives while it is withheld is remembered and then delivered as a fixed-width pulse. The hard reset path is never gated, and it clears all remembered state.

Top module: `smm_reset_gate`

## Requirements
- R1: `a20m_o` is 0 in every cycle in which `smi_act_i` is 1, combinationally in that same cycle.
- R2: In every cycle in which `smi_act_i` is 0, `a20m_o` equals `a20m_raw_i`.
- R3: When the gate is unblocked and `smi_req_i` or `smi_act_i` is sampled 1 at a clock edge, soft reset is blocked from the next cycle on. A `srst_raw_i` in that same cycle still reaches `srst_o`, because soft reset has priority over the management request.
- R4: Blocking continues through management mode until `smi_act_i` is sampled 0 after having been 1. It then continues for that cycle and for GUARD_CYCLES (default 20) further cycles.
- R5: A `bus_start_i` of 1 during the guard window ends blocking after that cycle. During management mode itself, `bus_start_i` has no effect.
- R6: `hard_rst_o` equals `hard_rst_i` in every cycle, with no gating.
- R7: While the gate is blocked, `srst_o` is 0 except for a replay pulse, and any `srst_raw_i` of 1 sets a pending flag.
- R8: At the first clock edge at which the gate is unblocked with a reset pending and no pulse running, a replay starts. `srst_o` is then 1 for exactly PULSE_W (default 4) cycles starting in the next cycle, and the pending flag clears.
- R9: `hard_rst_i` of 1 at a clock edge clears blocking, the guard window, the pending flag and any running pulse. A `smi_req_i` sampled at that edge is ignored. After `rst_ni` all outputs are 0 when the inputs are 0.
- R10: A `smi_req_i` or `smi_act_i` of 1 during the guard window returns the gate to management-mode blocking, and a pending soft reset is kept.
- R11: While the gate is unblocked and no pulse is running, `srst_o` equals `srst_raw_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the gate |
| smi_req_i | input | 1 | Management interrupt request seen by the processor |
| smi_act_i | input | 1 | Processor indication that it is in management mode |
| bus_start_i | input | 1 | One-cycle strobe marking the start of a bus cycle |
| a20m_raw_i | input | 1 | Address-wrap request from the chipset |
| srst_raw_i | input | 1 | Soft reset request from the chipset |
| hard_rst_i | input | 1 | Hard system reset |
| a20m_o | output | 1 | Gated address-wrap request to the processor |
| srst_o | output | 1 | Gated or replayed soft reset to the processor |
| hard_rst_o | output | 1 | Hard reset to the processor, passed through |

## Verification
Three kinds of result are due at different times. `a20m_o`, `hard_rst_o` and a passed-through soft reset are combinational and are due in the same cycle as their inputs. A change of blocking shows one cycle after the edge that samples the request, the falling active indication, the guard expiry or the bus-cycle strobe. A replay pulse begins one cycle after the first unblocked cycle and lasts PULSE_W cycles. The bench drives inputs just after each falling edge and compares all three outputs a short delay later against a behavioural model. That model advances only at rising edges, so every check falls inside the cycle whose value it names.

// File: rtl/smm_gate_pkg.sv
package smm_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_GUARD = 2'd2
  } smm_state_e;
endpackage

// File: rtl/smm_mode_tracker.sv
module smm_mode_tracker
  import smm_gate_pkg::*;
#(
  parameter int GUARD_CYCLES = 20,
  parameter int CNT_W        = $clog2(GUARD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic smi_req_i,
  input  logic smi_act_i,
  input  logic bus_start_i,
  output logic blocked_o
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(GUARD_CYCLES - 1);

  smm_state_e       state_q;
  logic             act_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (hard_rst_i) begin
      state_q <= ST_IDLE;
      act_q   <= smi_act_i;
      cnt_q   <= '0;
    end else begin
      act_q <= smi_act_i;
      unique case (state_q)
        ST_IDLE: if (smi_req_i || smi_act_i) state_q <= ST_HOLD;
        ST_HOLD: begin
          // leave on falling edge of the active indication
          if (act_q && !smi_act_i) begin
            state_q <= ST_GUARD;
            cnt_q   <= '0;
          end
        end
        ST_GUARD: begin
          if (smi_req_i || smi_act_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
          end else if (bus_start_i || cnt_q == LastCnt) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign blocked_o = (state_q != ST_IDLE);
endmodule

// File: rtl/srst_replay.sv
module srst_replay #(
  parameter int PULSE_W = 4,
  parameter int PW_W    = $clog2(PULSE_W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic blocked_i,
  input  logic srst_raw_i,
  output logic srst_o,
  output logic pending_o,
  output logic pulse_o
);
  logic            pending_q;
  logic [PW_W-1:0] pulse_cnt_q;
  logic            issue;

  assign pulse_o = (pulse_cnt_q != '0);
  assign issue   = !blocked_i && pending_q && !pulse_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q   <= 1'b0;
      pulse_cnt_q <= '0;
    end else if (hard_rst_i) begin
      pending_q   <= 1'b0;
      pulse_cnt_q <= '0;
    end else begin
      if (blocked_i && srst_raw_i) pending_q <= 1'b1;
      else if (issue)              pending_q <= 1'b0;

      if (issue)        pulse_cnt_q <= PW_W'(PULSE_W);
      else if (pulse_o) pulse_cnt_q <= pulse_cnt_q - 1'b1;
    end
  end

  assign srst_o    = (srst_raw_i && !blocked_i) || pulse_o;
  assign pending_o = pending_q;
endmodule

// File: rtl/smm_reset_gate.sv
module smm_reset_gate #(
  parameter int GUARD_CYCLES = 20,
  parameter int PULSE_W      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smi_req_i,
  input  logic smi_act_i,
  input  logic bus_start_i,
  input  logic a20m_raw_i,
  input  logic srst_raw_i,
  input  logic hard_rst_i,
  output logic a20m_o,
  output logic srst_o,
  output logic hard_rst_o
);
  localparam int CntW = $clog2(GUARD_CYCLES + 1);
  localparam int PwW  = $clog2(PULSE_W + 1);

  logic blocked;
  logic pending;
  logic pulse;

  smm_mode_tracker #(
    .GUARD_CYCLES(GUARD_CYCLES),
    .CNT_W       (CntW)
  ) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hard_rst_i (hard_rst_i),
    .smi_req_i  (smi_req_i),
    .smi_act_i  (smi_act_i),
    .bus_start_i(bus_start_i),
    .blocked_o  (blocked)
  );

  srst_replay #(
    .PULSE_W(PULSE_W),
    .PW_W   (PwW)
  ) u_replay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hard_rst_i(hard_rst_i),
    .blocked_i (blocked),
    .srst_raw_i(srst_raw_i),
    .srst_o    (srst_o),
    .pending_o (pending),
    .pulse_o   (pulse)
  );

  assign a20m_o     = a20m_raw_i && !smi_act_i;
  assign hard_rst_o = hard_rst_i;
endmodule

// File: rtl/smm_reset_gate_chk.sv
module smm_reset_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic smi_req_i,
  input logic smi_act_i,
  input logic srst_raw_i,
  input logic hard_rst_i,
  input logic hard_rst_o,
  input logic a20m_o,
  input logic srst_o,
  input logic blocked,
  input logic pending,
  input logic pulse
);
  // R1
  a20m_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_act_i |-> !a20m_o);

  // R6
  hard_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_o == hard_rst_i);

  // R3
  block_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blocked && smi_req_i && !hard_rst_i) |=> blocked);

  // R7
  latch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked && srst_raw_i && !hard_rst_i) |=> pending);

  // R7
  srst_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked && !pulse) |-> !srst_o);

  // R8
  replay_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && !blocked && !pulse && !hard_rst_i) |=> (pulse && !pending));

  // R9
  hard_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> (!blocked && !pending && !pulse));

  // R10
  pending_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked && pending && !hard_rst_i) |=> pending);
endmodule

bind smm_reset_gate smm_reset_gate_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smi_req_i (smi_req_i),
  .smi_act_i (smi_act_i),
  .srst_raw_i(srst_raw_i),
  .hard_rst_i(hard_rst_i),
  .hard_rst_o(hard_rst_o),
  .a20m_o    (a20m_o),
  .srst_o    (srst_o),
  .blocked   (blocked),
  .pending   (pending),
  .pulse     (pulse)
);

// File: tb/tb_smm_reset_gate.sv
`timescale 1ns/1ps
module tb_smm_reset_gate;
  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 20;
  localparam int PW         = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smi_req = 0, smi_act = 0, bus_start = 0, a20_raw = 0, srst_raw = 0, hard = 0;
  logic a20m_o, srst_o, hard_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_reset_gate #(.GUARD_CYCLES(GUARD), .PULSE_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .smi_req_i(smi_req), .smi_act_i(smi_act),
    .bus_start_i(bus_start), .a20m_raw_i(a20_raw), .srst_raw_i(srst_raw),
    .hard_rst_i(hard), .a20m_o(a20m_o), .srst_o(srst_o), .hard_rst_o(hard_rst_o)
  );

  // behavioural reference
  bit m_in_smm;
  int m_guard_left;
  bit m_pend;
  int m_pulse_left;
  bit m_act_prev;

  function automatic bit m_blocked();
    return m_in_smm || (m_guard_left > 0);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_in_smm = 0; m_guard_left = 0; m_pend = 0; m_pulse_left = 0; m_act_prev = 0;
    end else if (hard) begin
      m_in_smm = 0; m_guard_left = 0; m_pend = 0; m_pulse_left = 0; m_act_prev = smi_act;
    end else begin
      bit blk;
      blk = m_blocked();
      if (blk && srst_raw) m_pend = 1;
      else if (!blk && m_pend && m_pulse_left == 0) begin
        m_pend = 0;
        m_pulse_left = PW + 1;
      end
      if (m_pulse_left > 0) m_pulse_left--;
      if (m_in_smm) begin
        if (m_act_prev && !smi_act) begin
          m_in_smm = 0;
          m_guard_left = GUARD;
        end
      end else if (m_guard_left > 0) begin
        if (smi_req || smi_act) begin
          m_in_smm = 1; m_guard_left = 0;
        end else if (bus_start) m_guard_left = 0;
        else m_guard_left--;
      end else if (smi_req || smi_act) m_in_smm = 1;
      m_act_prev = smi_act;
    end
  end

  task automatic check_bit(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic cyc(logic req, logic act, logic bus, logic a20, logic srst, logic hr,
                     string tag);
    logic e_srst;
    smi_req = req; smi_act = act; bus_start = bus; a20_raw = a20; srst_raw = srst; hard = hr;
    #1;
    check_bit(act ? "R1" : "R2", "a20m_o", a20m_o, a20 && !act);
    check_bit("R6", "hard_rst_o", hard_rst_o, hr);
    e_srst = (srst && !m_blocked()) || (m_pulse_left > 0);
    check_bit(tag, "srst_o", srst_o, e_srst);
    @(negedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    check_bit("R9", "srst_o", srst_o, 1'b0);
    check_bit("R9", "a20m_o", a20m_o, 1'b0);
    check_bit("R9", "hard_rst_o", hard_rst_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 / R11 passthrough
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, "R2");
    cyc(0, 0, 0, 0, 1, 0, "R11");
    cyc(0, 0, 0, 1, 1, 0, "R11");
    idle(2, "R11");

    // R3 R4 R7 R8: soft reset during management mode, replay after guard
    cyc(1, 0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 0, 1, 1, 0, "R3");
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, 1, (i % 3) == 1, 0, "R7");
    for (int i = 0; i < GUARD + PW + 4; i++) cyc(0, 0, 0, 1, 0, 0, "R4");
    idle(2, "R8");

    // R5: bus-cycle start shortens the guard, ignored in management mode
    cyc(1, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 5; i++) cyc(0, 1, i == 2, 0, i == 1, 0, "R5");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, 0, "R5");
    idle(PW + 3, "R8");

    // R10: new request during guard window keeps pending reset
    cyc(1, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, i == 0, 0, "R7");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, "R10");
    cyc(1, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 0, "R10");
    idle(GUARD + PW + 4, "R10");

    // R9: hard reset clears a pending soft reset and ignores a request
    cyc(1, 0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R9");
    idle(GUARD + PW + 2, "R9");
    cyc(1, 0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 0, 1, 0, "R9");
    idle(2, "R9");

    // R8: raw reset in the pulse-start cycle and back-to-back requests
    cyc(1, 0, 0, 0, 1, 0, "R3");
    cyc(0, 1, 0, 0, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, "R4");
    for (int i = 0; i < GUARD + PW + 3; i++) cyc(0, 0, 0, 0, i == GUARD + 1, 0, "R8");
    idle(3, "R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule